// File: doc/BRIEF.md
# Parallel-Port Host FIFO with Service-Interrupt Latch

This block holds the byte queue that a parallel-port host controller uses for its buffered transfer modes, together with the extended control register that governs when the host is asked for service. The host side pushes and pops bytes through one shared 16-entry queue and reads or writes an 8-bit control register. The register reports the queue's full and empty state. It also carries the DMA enable, the mode field, an active-low error-interrupt enable and the service flag.

The service flag is a latch. While it reads 0, the block watches for a service event. With DMA on, the event is the DMA terminal count. With DMA off and the direction input at 0 (host sending), the event is at least 8 free entries. With DMA off and direction at 1 (host receiving), the event is at least 8 stored bytes. On the event, hardware sets the flag and emits a one-cycle interrupt pulse. A set flag blocks every further interrupt and the DMA request until software writes the flag back to 0.

Top module: `ecp_fifo_ctl`

## Requirements
- R1: Bytes pushed into the queue come out of the pop data port in the order they were pushed; the queue holds 16 bytes.
- R2: The full port and register bit 1 read 1 exactly when 16 bytes are stored; a push while full is dropped and leaves the count unchanged.
- R3: The empty port and register bit 0 read 1 exactly when no byte is stored; a pop while empty is ignored.
- R4: A register write loads mode (bits 7:5), the active-low error-interrupt enable (bit 4), DMA enable (bit 3) and the service flag (bit 2); written values for bits 1:0 have no effect, and those bits always show full and empty.
- R5: After reset the queue is empty and the register reads 0x15: mode 000, error-interrupt enable 1, DMA off, service flag 1, empty 1.
- R6: Once the service flag is 1, it stays 1 until software writes 0 to it. Software writing 1 to the flag produces no interrupt pulse.
- R7: With DMA enabled and the flag at 0, a terminal-count input sets the flag at the next clock edge; FIFO fill levels do not set the flag in this mode.
- R8: With DMA disabled, direction 0 and the flag at 0, the flag is set at the next edge when 8 or more entries are free, and not while fewer are free.
- R9: With DMA disabled, direction 1 and the flag at 0, the flag is set at the next edge when 8 or more bytes are stored, and not while fewer are stored.
- R10: The interrupt output pulses high for exactly one cycle, in the cycle in which hardware has just set the flag.
- R11: The DMA request output is 1 only when DMA is enabled, the flag is 0, and the queue is ready for the current direction: not full for direction 0, not empty for direction 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Push the byte on push_data |
| push_data | input | 8 | Byte to store |
| pop | input | 1 | Remove the head byte |
| pop_data | output | 8 | Head byte of the queue (valid when not empty) |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register read value |
| xfer_dir | input | 1 | Transfer direction: 0 host to peripheral, 1 peripheral to host |
| dma_tc | input | 1 | DMA terminal count reached |
| full | output | 1 | Queue holds 16 bytes |
| empty | output | 1 | Queue holds no byte |
| svc_irq | output | 1 | One-cycle service interrupt pulse |
| dma_req | output | 1 | DMA transfer request |

## Verification
The assertions assume that push, pop, reg_we and dma_tc are stable around the rising clock edge. They also assume that software holds xfer_dir constant while it waits for a threshold event. The bench changes every input half a cycle away from the rising edge. It changes the direction only while the flag is set or before it clears the flag. The random phase runs with the flag left set from reset, so the queue checks never overlap an interrupt. The threshold and terminal-count cases are driven directly, one event at a time.

// File: rtl/ecpf_pkg.sv
package ecpf_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam int unsigned BIT_MODE_HI = 7;
  localparam int unsigned BIT_MODE_LO = 5;
  localparam int unsigned BIT_NERR    = 4;
  localparam int unsigned BIT_DMA     = 3;
  localparam int unsigned BIT_FLAG    = 2;
  localparam int unsigned BIT_FULL    = 1;
  localparam int unsigned BIT_EMPTY   = 0;

  typedef struct packed {
    logic [2:0] mode;
    logic       nerr_en;
    logic       dma_en;
    logic       svc_flag;
  } ctl_fields_t;

  localparam ctl_fields_t CTL_RESET = '{mode: 3'b000, nerr_en: 1'b1,
                                        dma_en: 1'b0, svc_flag: 1'b1};
endpackage

// File: rtl/ecpf_store.sv
module ecpf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full     = (cnt_q == CNT_MAX);
  assign empty    = (cnt_q == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign pop_data = mem[rd_ptr_q];
  assign count    = cnt_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == PTR_MAX) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr_q == PTR_MAX) ? '0 : rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  a_r2_push_full_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
  a_r3_pop_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/ecpf_svc.sv
module ecpf_svc #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WR_THR = 8,
  parameter int unsigned RD_THR = 8,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          dma_en,
  input  logic          svc_flag,
  input  logic          xfer_dir,
  input  logic          dma_tc,
  input  logic [CW-1:0] count,
  input  logic          full,
  input  logic          empty,
  output logic          svc_event,
  output logic          dma_req
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [CW-1:0] WR_LIM  = CW'(WR_THR);
  localparam logic [CW-1:0] RD_LIM  = CW'(RD_THR);

  logic [CW-1:0] free_cnt;
  logic          room_ok, fill_ok, port_ready;

  assign free_cnt   = CNT_MAX - count;
  assign room_ok    = (free_cnt >= WR_LIM);
  assign fill_ok    = (count >= RD_LIM);
  assign port_ready = xfer_dir ? !empty : !full;

  always_comb begin
    if (dma_en)        svc_event = dma_tc;
    else if (xfer_dir) svc_event = fill_ok;
    else               svc_event = room_ok;
  end

  assign dma_req = dma_en && !svc_flag && port_ready;
endmodule

// File: rtl/ecpf_ctl_reg.sv
module ecpf_ctl_reg
  import ecpf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              svc_event,
  input  logic              full,
  input  logic              empty,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              dma_en,
  output logic              svc_flag,
  output logic              svc_irq
);
  ctl_fields_t cur_q, nxt_d;
  logic        hw_set, irq_q;

  assign hw_set = !cur_q.svc_flag && svc_event;

  always_comb begin
    nxt_d = cur_q;
    if (reg_we) begin
      nxt_d.mode     = reg_wdata[BIT_MODE_HI:BIT_MODE_LO];
      nxt_d.nerr_en  = reg_wdata[BIT_NERR];
      nxt_d.dma_en   = reg_wdata[BIT_DMA];
      nxt_d.svc_flag = reg_wdata[BIT_FLAG];
    end
    if (hw_set) nxt_d.svc_flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= CTL_RESET;
      irq_q <= 1'b0;
    end else begin
      cur_q <= nxt_d;
      irq_q <= hw_set;
    end
  end

  assign reg_rdata = {cur_q.mode, cur_q.nerr_en, cur_q.dma_en,
                      cur_q.svc_flag, full, empty};
  assign dma_en    = cur_q.dma_en;
  assign svc_flag  = cur_q.svc_flag;
  assign svc_irq   = irq_q;

  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q.svc_flag && !reg_we) |=> cur_q.svc_flag);
  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    svc_irq |=> !svc_irq);
  a_r10_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    svc_irq |-> cur_q.svc_flag);
endmodule

// File: rtl/ecp_fifo_ctl.sv
module ecp_fifo_ctl
  import ecpf_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WR_THR = 8,
  parameter int unsigned RD_THR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              pop,
  output logic [BYTE_W-1:0] pop_data,
  input  logic              reg_we,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              xfer_dir,
  input  logic              dma_tc,
  output logic              full,
  output logic              empty,
  output logic              svc_irq,
  output logic              dma_req
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          dma_en, svc_flag, svc_event;

  ecpf_store #(.DEPTH(DEPTH), .DW(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(pop_data), .count(count), .full(full), .empty(empty)
  );

  ecpf_svc #(.DEPTH(DEPTH), .WR_THR(WR_THR), .RD_THR(RD_THR)) u_svc (
    .dma_en(dma_en), .svc_flag(svc_flag), .xfer_dir(xfer_dir), .dma_tc(dma_tc),
    .count(count), .full(full), .empty(empty),
    .svc_event(svc_event), .dma_req(dma_req)
  );

  ecpf_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .svc_event(svc_event), .full(full), .empty(empty),
    .reg_rdata(reg_rdata), .dma_en(dma_en), .svc_flag(svc_flag),
    .svc_irq(svc_irq)
  );

  a_r11_req_needs_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (!reg_rdata[BIT_FLAG] && reg_rdata[BIT_DMA]));
  a_r2_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  a_r4_status_bits_track: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[BIT_FULL] == full) && (reg_rdata[BIT_EMPTY] == empty));
endmodule

// File: tb/sim_ecp_fifo_ctl.sv
`timescale 1ns/1ps
module sim_ecp_fifo_ctl;
  logic       clk = 1'b0;
  logic       rst_n, push, pop, reg_we, xfer_dir, dma_tc;
  logic [7:0] push_data, reg_wdata, pop_data, reg_rdata;
  logic       full, empty, svc_irq, dma_req;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mq [$];

  always #2.5 clk = ~clk;

  ecp_fifo_ctl u0 (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .xfer_dir(xfer_dir), .dma_tc(dma_tc),
    .full(full), .empty(empty), .svc_irq(svc_irq), .dma_req(dma_req)
  );

  function automatic logic [1:0] exp_stat(input int cnt);
    return {cnt == 16, cnt == 0};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    push = 0; pop = 0; reg_we = 0; dma_tc = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; push = 0; pop = 0; reg_we = 0; dma_tc = 0;
    push_data = 0; reg_wdata = 0;
    mq.delete();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk); reg_we = 1; reg_wdata = v; tick();
  endtask

  task automatic push1(input logic [7:0] v);
    @(negedge clk); push = 1; push_data = v; tick();
    mq.push_back(v);
  endtask

  task automatic pop1();
    @(negedge clk);
    check("R1 pop order", pop_data, mq[0]);
    pop = 1; tick();
    void'(mq.pop_front());
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tick(); end
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; xfer_dir = 0;
    do_reset();
    @(posedge clk); #1;
    // R5 reset state
    check("R5 reg reset", reg_rdata, 8'h15);
    check("R5 empty/full", {6'd0, full, empty}, 8'h01);
    check("R5 no irq/req", {6'd0, svc_irq, dma_req}, 8'h00);

    // R1 R2 R3 random push/pop with the flag left set
    for (int i = 0; i < 3000; i++) begin
      logic p, q, ok_push, ok_pop;
      logic [7:0] d;
      int bias;
      bias = (i / 300) % 2;
      @(negedge clk);
      p = (($urandom % 4) < (bias ? 3 : 1));
      q = (($urandom % 4) < (bias ? 1 : 3));
      d = 8'($urandom);
      ok_push = p && mq.size() < 16;
      ok_pop  = q && mq.size() > 0;
      if (ok_pop) check("R1 head data", pop_data, mq[0]);
      push = p; pop = q; push_data = d;
      tick();
      if (ok_pop) void'(mq.pop_front());
      if (ok_push) mq.push_back(d);
      check("R2 R3 full/empty", {6'd0, full, empty}, {6'd0, exp_stat(mq.size())});
      check("R6 flag kept, no irq", {reg_rdata[2], svc_irq}, 8'h02);
    end

    // R8 direction 0, empty FIFO: event when clearing the flag
    do_reset(); xfer_dir = 0;
    wr_reg(8'h10);
    check("R8 flag cleared", reg_rdata, 8'h11);
    check("R10 no irq yet", {7'd0, svc_irq}, 8'h00);
    idle(1);
    check("R8 flag set by room", reg_rdata, 8'h15);
    check("R10 irq pulse", {7'd0, svc_irq}, 8'h01);
    idle(1);
    check("R10 irq one cycle", {7'd0, svc_irq}, 8'h00);
    check("R6 flag held", reg_rdata, 8'h15);

    // R9 direction 1: no event below 8 stored bytes
    xfer_dir = 1;
    wr_reg(8'h10);
    idle(3);
    check("R9 below threshold", reg_rdata, 8'h11);
    for (int k = 0; k < 7; k++) push1(8'hA0 + 8'(k));
    check("R9 seven stored", {reg_rdata, svc_irq}, {8'h10, 1'b0});
    push1(8'hA7);
    check("R9 eighth stored no set yet", reg_rdata, 8'h10);
    idle(1);
    check("R9 flag set at eight", {reg_rdata, svc_irq}, {8'h14, 1'b1});

    // R8 direction 0 with only 7 free
    push1(8'hA8);
    xfer_dir = 0;
    wr_reg(8'h10);
    idle(2);
    check("R8 seven free no set", {reg_rdata, svc_irq}, {8'h10, 1'b0});
    pop1();
    check("R8 eight free pending", reg_rdata, 8'h10);
    idle(1);
    check("R8 flag set at eight free", {reg_rdata, svc_irq}, {8'h14, 1'b1});

    // R7 R11 DMA mode, direction 0, 8 stored
    wr_reg(8'h18);
    check("R11 req raised", {reg_rdata, dma_req}, {8'h18, 1'b1});
    idle(2);
    check("R7 thresholds ignored", {reg_rdata, svc_irq}, {8'h18, 1'b0});
    @(negedge clk); dma_tc = 1; tick();
    check("R7 tc sets flag", {reg_rdata, svc_irq}, {8'h1C, 1'b1});
    check("R11 req dropped", {7'd0, dma_req}, 8'h00);

    // R6 software writes 1: no interrupt
    wr_reg(8'h18);
    wr_reg(8'h1C);
    check("R6 sw set no irq", {reg_rdata, svc_irq}, {8'h1C, 1'b0});
    idle(1);
    check("R6 sw set no irq later", {7'd0, svc_irq}, 8'h00);

    // R11 direction 1 gating by empty
    do_reset(); xfer_dir = 1;
    @(posedge clk); #1;
    wr_reg(8'h18);
    check("R11 empty no req", {reg_rdata, dma_req}, {8'h19, 1'b0});
    push1(8'h5A);
    check("R11 data ready req", {reg_rdata, dma_req}, {8'h18, 1'b1});

    // R4 field write, read-only status bits
    wr_reg(8'hE3);
    check("R4 fields and status", reg_rdata, 8'hE0);

    // R2 fill to full, push while full dropped
    wr_reg(8'hE4);
    for (int k = 1; k < 16; k++) push1(8'(k));
    check("R2 full", {6'd0, full, empty}, 8'h02);
    check("R2 status bits", {6'd0, reg_rdata[1:0]}, 8'h02);
    @(negedge clk); push = 1; push_data = 8'hFF; tick();
    for (int k = 0; k < 16; k++) pop1();
    check("R3 empty after drain", {6'd0, full, empty}, 8'h01);
    @(negedge clk); pop = 1; tick();
    check("R3 pop on empty ignored", {6'd0, full, empty}, 8'h01);
    push1(8'h3C);
    pop1();

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule